// File: doc/BRIEF.md
# Three-Stage Over-Temperature Alarm

This block watches a digital die-temperature value and classifies it into one of four over-temperature stages, 0 (normal) through 3 (critical). Each stage boundary comes from one of four fixed threshold rows, and a 2-bit field in the shutdown control register picks the row. The block drives two shutdown outputs: a stage-2 output that software can mask, and a stage-3 output that cannot be masked. It raises an interrupt whenever the stage moves.

The temperature input is sampled only on an internal rate tick, and the monitor evaluates nothing until software turns it on. A stage rises at once to the highest boundary that has been met. It falls only one step per tick, and only after the sample has dropped 2 °C below the boundary of the current stage. Software reaches the block through an 8-bit address/data port with separate read and write strobes. The port also returns fixed identification bytes.

Top module: `otemp_alarm`

## Requirements
- R1: The temperature input is a signed 16-bit value in units of 1/8 °C. For threshold row s (0..3), stage k (1..3) trips at 105 + 20·(k−1) + 5·s °C. The comparison is signed, so negative samples fall below every boundary.
- R2: On an evaluation tick, when the sample meets or exceeds the boundary of a stage above the current one, the stage jumps to the highest such stage.
- R3: On an evaluation tick with no rise, the stage drops by exactly one when the sample is at or below the current stage's boundary minus 2 °C (16 counts). Otherwise it holds.
- R4: An evaluation tick occurs every 2^TICK_EXP clocks when bit 3 of the shutdown control register (0x40) is set, and every 4·2^TICK_EXP clocks when it is clear.
- R5: Bit 7 of the alarm control register (0x46) enables the monitor. While that bit is 0 the stage holds its value, whatever the input.
- R6: `shdn2` is high when the stage is 2 or 3 and bit 6 of register 0x40 is 0. `shdn3` is high when the stage is 3, whatever bit 6 holds.
- R7: A read of the status register (0x08) returns the stage in bits [1:0] and zero in the bits above.
- R8: An interrupt-pending flag, readable at bit 0 of 0x10 and driven onto `irq`, sets on every stage change. Writing 1 to bit 0 of 0x10 clears it. A set in the same cycle wins over the clear.
- R9: Identification reads return 0x09 at 0x04, 0x08 at 0x05, MAJOR_REV at 0x01 and MINOR_REV at 0x00. Writes to these offsets do nothing.
- R10: After reset the stage is 0, `irq`, `shdn2` and `shdn3` are low, and registers 0x40 and 0x46 read 0x00. This means row 0, the slow rate, no override and the monitor off.
- R11: Reads of unmapped offsets return 0x00, and writes to them change no register. `reg_rdata` loads on a clock edge where `reg_re` is high and holds its value otherwise.
- R12: Register 0x40 keeps only bits 1:0, 3 and 6. The other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_in | input | 16 | Signed temperature, 1/8 °C per count |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| stage | output | 2 | Current over-temperature stage |
| shdn2 | output | 1 | Maskable stage-2 shutdown |
| shdn3 | output | 1 | Stage-3 shutdown |
| irq | output | 1 | Stage-change interrupt |

## Verification
The assertions assume that `temp_in` and the register strobes change only between clock edges, and that `reg_we` and `reg_re` are never high at once for the same offset. The bench drives every input on the falling edge and issues one access at a time, so it stays within those assumptions. Stage checks are made only after several fast-rate ticks, so that multi-step falls have settled. The tick period is measured from one stage change to the next.

// File: rtl/otemp_pkg.sv
package otemp_pkg;
  localparam int TEMP_W    = 16;
  localparam int FRAC      = 8;    // counts per degree
  localparam int BASE_C    = 105;
  localparam int STAGE_C   = 20;
  localparam int ROW_C     = 5;
  localparam int HYST_C    = 2;
  localparam int NSTAGE    = 3;

  localparam logic [7:0] A_MINOR  = 8'h00;
  localparam logic [7:0] A_MAJOR  = 8'h01;
  localparam logic [7:0] A_TYPE   = 8'h04;
  localparam logic [7:0] A_SUBT   = 8'h05;
  localparam logic [7:0] A_STATUS = 8'h08;
  localparam logic [7:0] A_IRQ    = 8'h10;
  localparam logic [7:0] A_SDCTL  = 8'h40;
  localparam logic [7:0] A_ALCTL  = 8'h46;

  localparam logic [7:0] ID_TYPE  = 8'h09;
  localparam logic [7:0] ID_SUBT  = 8'h08;

  typedef logic [1:0] stage_t;

  // Boundary of stage stg (1..3) for threshold row rsel, in 1/8 degree, widened by one bit
  function automatic logic signed [TEMP_W:0] trip_level(input logic [1:0] rsel, input stage_t stg);
    int deg;
    deg = BASE_C + STAGE_C * (int'(stg) - 1) + ROW_C * int'(rsel);
    return (TEMP_W+1)'(deg * FRAC);
  endfunction

  function automatic logic signed [TEMP_W:0] hyst_counts();
    return (TEMP_W+1)'(HYST_C * FRAC);
  endfunction
endpackage

// File: rtl/otemp_tick.sv
module otemp_tick #(
  parameter int TICK_EXP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  localparam int CW = TICK_EXP + 3;
  localparam logic [CW-1:0] LIM_FAST = CW'((1 << TICK_EXP) - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'((4 << TICK_EXP) - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? LIM_FAST : LIM_SLOW;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/otemp_stage.sv
module otemp_stage
  import otemp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] sample,
  input  logic [1:0]               rsel,
  input  logic                     tick,
  input  logic                     en,
  output stage_t                   stage,
  output logic                     chg
);
  logic signed [TEMP_W:0] samp_x;
  stage_t                 tgt;
  stage_t                 nxt;
  logic                   down_ok;

  assign samp_x = {sample[TEMP_W-1], sample};

  always_comb begin
    tgt = '0;
    for (int k = 1; k <= NSTAGE; k++) begin
      if (samp_x >= trip_level(rsel, stage_t'(k))) tgt = stage_t'(k);
    end
  end

  assign down_ok = (stage != '0) &&
                   (samp_x <= (trip_level(rsel, stage) - hyst_counts()));

  always_comb begin
    nxt = stage;
    if (tick && en) begin
      if (tgt > stage) nxt = tgt;
      else if (down_ok) nxt = stage - 1'b1;
    end
  end

  assign chg = (nxt != stage);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= '0;
    else stage <= nxt;
  end
endmodule

// File: rtl/otemp_regs.sv
module otemp_regs
  import otemp_pkg::*;
#(
  parameter logic [7:0] MAJOR_REV = 8'h01,
  parameter logic [7:0] MINOR_REV = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       we,
  input  logic       re,
  input  stage_t     stage,
  input  logic       chg,
  output logic [7:0] rdata,
  output logic [1:0] rsel,
  output logic       fast,
  output logic       ovr,
  output logic       mon_en,
  output logic       pend
);
  logic [7:0] rd_mux;
  logic       wr_sd, wr_al, clr_irq;

  assign wr_sd   = we && (addr == A_SDCTL);
  assign wr_al   = we && (addr == A_ALCTL);
  assign clr_irq = we && (addr == A_IRQ) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel <= '0; fast <= 1'b0; ovr <= 1'b0;
    end else if (wr_sd) begin
      rsel <= wdata[1:0]; fast <= wdata[3]; ovr <= wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mon_en <= 1'b0;
    else if (wr_al) mon_en <= wdata[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (chg) pend <= 1'b1;
    else if (clr_irq) pend <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_MINOR:  rd_mux = MINOR_REV;
      A_MAJOR:  rd_mux = MAJOR_REV;
      A_TYPE:   rd_mux = ID_TYPE;
      A_SUBT:   rd_mux = ID_SUBT;
      A_STATUS: rd_mux = {6'b0, stage};
      A_IRQ:    rd_mux = {7'b0, pend};
      A_SDCTL:  rd_mux = {1'b0, ovr, 2'b0, fast, 1'b0, rsel};
      A_ALCTL:  rd_mux = {mon_en, 7'b0};
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else if (re) rdata <= rd_mux;
  end
endmodule

// File: rtl/otemp_alarm.sv
module otemp_alarm
  import otemp_pkg::*;
#(
  parameter int         TICK_EXP  = 4,
  parameter logic [7:0] MAJOR_REV = 8'h01,
  parameter logic [7:0] MINOR_REV = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] temp_in,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_we,
  input  logic        reg_re,
  output logic [7:0]  reg_rdata,
  output logic [1:0]  stage,
  output logic        shdn2,
  output logic        shdn3,
  output logic        irq
);
  logic [1:0] rsel_w;
  logic       fast_w, ovr_w, mon_en_w, tick_w, stg_chg_w, pend_w;
  stage_t     stage_w;

  otemp_regs #(.MAJOR_REV(MAJOR_REV), .MINOR_REV(MINOR_REV)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .re(reg_re), .stage(stage_w), .chg(stg_chg_w),
    .rdata(reg_rdata), .rsel(rsel_w), .fast(fast_w), .ovr(ovr_w),
    .mon_en(mon_en_w), .pend(pend_w)
  );

  otemp_tick #(.TICK_EXP(TICK_EXP)) u_tick (
    .clk(clk), .rst_n(rst_n), .fast(fast_w), .tick(tick_w)
  );

  otemp_stage u_stage (
    .clk(clk), .rst_n(rst_n), .sample(temp_in), .rsel(rsel_w),
    .tick(tick_w), .en(mon_en_w), .stage(stage_w), .chg(stg_chg_w)
  );

  assign stage = stage_w;
  assign shdn2 = (stage_w >= 2'd2) && !ovr_w;
  assign shdn3 = (stage_w == 2'd3);
  assign irq   = pend_w;
endmodule

// File: rtl/otemp_alarm_chk.sv
module otemp_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] stage,
  input logic       tick_w,
  input logic       mon_en_w,
  input logic       stg_chg_w,
  input logic       ovr_w,
  input logic       shdn2,
  input logic       shdn3,
  input logic       irq
);
  // R4, R5: stage moves only on an enabled tick
  p_hold_off_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_w && mon_en_w) |=> $stable(stage));

  // R3: a fall is always a single step
  p_single_step_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage < $past(stage)) |-> ($past(stage) == stage + 2'd1));

  // R8: a change always leaves the flag pending
  p_irq_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stg_chg_w |=> irq);

  // R8: the flag rises only together with a stage move
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stage != $past(stage)));

  // R6: stage-3 shutdown implies stage-2 shutdown unless overridden
  p_shdn_nesting_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shdn3 |-> (shdn2 || ovr_w));
endmodule

bind otemp_alarm otemp_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stage(stage), .tick_w(tick_w),
  .mon_en_w(mon_en_w), .stg_chg_w(stg_chg_w), .ovr_w(ovr_w),
  .shdn2(shdn2), .shdn3(shdn3), .irq(irq)
);

// File: tb/sim_otemp_alarm.sv
`timescale 1ns/1ps
module sim_otemp_alarm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] temp_in = '0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_rdata;
  logic [1:0]  stage;
  logic        shdn2, shdn3, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  otemp_alarm u0 (.*);

  // {row[1:0], temp[15:0], expected settled stage[1:0]}; temp in 1/8 degC
  localparam logic [19:0] VECS [0:11] = '{
    {2'd0, 16'd800,  2'd0},   // 100 C
    {2'd0, 16'd840,  2'd1},   // 105 C exact boundary
    {2'd0, 16'd1168, 2'd3},   // 146 C
    {2'd0, 16'd1152, 2'd3},   // 144 C inside hysteresis
    {2'd0, 16'd1144, 2'd2},   // 143 C one step down
    {2'd0, 16'd720,  2'd0},   // 90 C falls to 0 over ticks
    {2'd0, 16'd1000, 2'd2},   // 125 C
    {2'd0, 16'd992,  2'd2},   // 124 C held
    {2'd3, 16'd992,  2'd1},   // row 3: 120/140/160
    {2'd3, 16'd1280, 2'd3},   // 160 C
    {2'd3, 16'hFCE0, 2'd0},   // -100 C
    {2'd2, 16'd1080, 2'd2}    // row 2: 135 C
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  // period between two consecutive stage changes with temp flipped right after the first
  task automatic measure(output int n);
    int guard;
    temp_in = 16'd2000; settle();
    wr(8'h10, 8'h01);
    temp_in = 16'd0;
    guard = 0;
    while (!irq && guard < 1000) begin @(negedge clk); guard++; end
    temp_in = 16'd2000;
    reg_addr = 8'h10; reg_wdata = 8'h01; reg_we = 1'b1;
    n = 0;
    do begin
      @(negedge clk); reg_we = 1'b0; n++;
    end while (!irq && n < 1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 stage", stage, 0);
    check("R10 irq", irq, 0);
    check("R10 shdn", {shdn2, shdn3}, 0);
    rd(8'h40, d); check("R10 sdctl", d, 8'h00);
    rd(8'h46, d); check("R10 alctl", d, 8'h00);
    // R9 identification
    rd(8'h04, d); check("R9 type", d, 8'h09);
    rd(8'h05, d); check("R9 subtype", d, 8'h08);
    rd(8'h01, d); check("R9 major", d, 8'h01);
    rd(8'h00, d); check("R9 minor", d, 8'h00);
    wr(8'h04, 8'h55); rd(8'h04, d); check("R9 type write ignored", d, 8'h09);
    // R5 monitor off: no evaluation
    temp_in = 16'd2000; settle();
    check("R5 disabled stage", stage, 0);
    check("R5 disabled irq", irq, 0);
    wr(8'h40, 8'h08); wr(8'h46, 8'h80);
    settle();
    check("R2 enabled stage", stage, 3);
    check("R8 irq set", irq, 1);
    rd(8'h10, d); check("R8 pending read", d, 8'h01);
    wr(8'h10, 8'h01);
    check("R8 irq cleared", irq, 0);
    rd(8'h10, d); check("R8 pending read clear", d, 8'h00);
    wr(8'h46, 8'h00); temp_in = 16'd0; settle();
    check("R5 hold while off", stage, 3);
    check("R8 no change no irq", irq, 0);
    wr(8'h46, 8'h80); settle();
    check("R3 falls after re-enable", stage, 0);
    // R1, R2, R3, R6, R7 vector walk, fast rate
    foreach (VECS[i]) begin
      wr(8'h40, {4'b0000, 1'b1, 1'b0, VECS[i][19:18]});
      temp_in = VECS[i][17:2];
      settle();
      check($sformatf("R1 R2 R3 vec%0d stage", i), stage, VECS[i][1:0]);
      check($sformatf("R6 vec%0d shdn2", i), shdn2, VECS[i][1:0] >= 2 ? 1 : 0);
      check($sformatf("R6 vec%0d shdn3", i), shdn3, VECS[i][1:0] == 3 ? 1 : 0);
      rd(8'h08, d);
      check($sformatf("R7 vec%0d status", i), d, {6'b0, VECS[i][1:0]});
    end
    // R6 override: row 2, stage 2 then 3
    wr(8'h40, 8'h4A);
    @(negedge clk);
    check("R6 override masks shdn2", shdn2, 0);
    temp_in = 16'd1240; settle();
    check("R6 stage 3", stage, 3);
    check("R6 shdn3 ignores override", shdn3, 1);
    check("R6 shdn2 masked at 3", shdn2, 0);
    rd(8'h40, d); check("R12 readback", d, 8'h4A);
    wr(8'h40, 8'hFF); rd(8'h40, d); check("R12 kept bits", d, 8'h4B);
    // R11 unmapped
    wr(8'h40, 8'h08);
    wr(8'h20, 8'hFF); rd(8'h20, d); check("R11 unmapped read", d, 8'h00);
    wr(8'h08, 8'hFF); rd(8'h08, d); check("R11 status write ignored", d, 8'h03);
    rd(8'h40, d); check("R11 sdctl untouched", d, 8'h08);
    @(negedge clk); reg_addr = 8'h04;
    @(negedge clk); check("R11 rdata holds without re", reg_rdata, 8'h08);
    // R4 tick period
    measure(per); check("R4 fast period", per, 16);
    wr(8'h40, 8'h00);
    measure(per); check("R4 slow period", per, 64);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule